// File: doc/BRIEF.md
# Descriptor-chained audio DMA engine

This block moves 32-bit audio words between system memory and a fixed device data port, in either direction. Software keeps its commands in a 64-bit order register. A write to that register can launch the engine at a descriptor address, halt it, or have it store its live descriptor state to a chosen address. Each descriptor names a buffer, a word count, a direction and an interrupt option. It also carries a link to the next descriptor, so a ring of descriptors gives a continuous audio stream.

The engine reads a descriptor with single-word memory reads. It then performs the transfer one word at a time. In playback it reads memory and offers the word to the device. In capture it takes a word from the device and writes it to memory. While it runs, it advances the source address held in its live copy of the descriptor, so a write-back shows the current buffer position. At the end of a descriptor it can raise a level interrupt, and it follows the link when the link is valid.

Both the memory request port and the device ports use valid/ready. A request or device word, once offered with valid high, is held with stable contents until ready is seen. Read data comes back on a response strobe, which the engine always accepts. Only one memory access is outstanding at any time. The engine applies back-pressure to the capture source by holding ready low whenever it is not waiting for a device word.

Top module: `chain_dma`

## Requirements
- R1: After reset the interrupt is low and no memory request, device word or capture ready is driven. Register select 0 (order low) and select 2 (status) both read 0.
- R2: Writing order-low with bit 3 set starts the engine. It fetches a descriptor from address {order-high, order-low[31:5], 5'b0}, and bit 3 then reads back as 0.
- R3: A descriptor is fetched as 10 consecutive words at byte offsets 0..36. Word 0 is link-low, whose bit 0 marks the link valid. The remaining words are: 1 source-low, 2 device address, 3 length, 4 stride, 5 repeat, 6 command, 7 status, 8 link-high, 9 source-high.
- R4: The length field counts 32-bit words. The source address advances by 4 after each word, and every memory address is word aligned.
- R5: Command bit 12 set selects playback: memory is read at the source address and the word is offered on the device transmit port. Bit 12 clear selects capture: device receive words are written to memory at the source address. Transmit valid and receive ready are never high together.
- R6: At the end of a descriptor, a valid link makes the engine fetch the linked descriptor, and a link back to an earlier descriptor forms a ring. An invalid link returns the engine to idle with no further memory requests.
- R7: When command bit 0 is set, the end of the descriptor raises the interrupt. The interrupt stays high until software writes 1 to status bit 0 (register select 2).
- R8: Writing order-low with bit 2 set makes the engine store its 10 live words at the order address at the next word boundary. The stored source field shows the current position. Bit 2 then reads back as 0 and the transfer carries on.
- R9: Writing order-low with bit 4 set halts the engine at the next word boundary. Bit 4 reads back as 0 once the engine is idle, and after that no memory request or device word is issued.
- R10: With order-low bit 0 clear, the upper 32 bits of every memory address are driven as zero. With bit 0 set, the full 64-bit address is used.
- R11: Each descriptor moves `length` words `repeat` times, with a repeat of 0 treated as 1. After each block except the last, the source address also advances by `stride` bytes. A stride of 0 with a repeat of 1 gives one linear transfer.
- R12: A memory request held without ready keeps valid, address, write enable and write data stable. A transmit word held without ready keeps valid and data stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 order low, 1 order high, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel (combinational) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 for a write request, 0 for a read |
| mem_req_addr | output | 64 | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Read data |
| dev_tx_valid | output | 1 | Playback word valid |
| dev_tx_ready | input | 1 | Device accepts playback word |
| dev_tx_data | output | 32 | Playback word |
| dev_rx_valid | input | 1 | Capture word valid |
| dev_rx_ready | output | 1 | Engine accepts capture word |
| dev_rx_data | input | 32 | Capture word |
| irq | output | 1 | Level-high end-of-descriptor interrupt |

## Verification
The assertions check several properties on every cycle. Requests and transmit words must stay stable under back-pressure. Addresses must be word aligned, and the upper address half must be zero in 32-bit mode. The two directions must never be active together. A pending interrupt must hold until its clear is written. The ordering behaviour can only be shown by the bench's scenarios, which compare the observed data and memory contents with independently computed values. That covers which memory words reach the device and in what sequence, where capture data lands, how the ring wraps, and what the write-back stores. The same applies to how stride and repeat reshape the address sequence, and to the engine going quiet after a halt.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;
  localparam int ADDR_W     = 64;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 10;               // live words fetched and stored back
  localparam int IDX_W      = $clog2(DESC_WORDS);
  localparam int ALIGN_LSB  = 5;                // descriptors are 32-byte aligned
  localparam int REG_SEL_W  = 2;

  // order register bits
  localparam int ORD_A64  = 0;
  localparam int ORD_UNC  = 1;
  localparam int ORD_WB   = 2;
  localparam int ORD_GO   = 3;
  localparam int ORD_HALT = 4;

  // descriptor word indices (fetch/store order)
  localparam int W_LINK_LO = 0;
  localparam int W_SRC_LO  = 1;
  localparam int W_DEV     = 2;
  localparam int W_LEN     = 3;
  localparam int W_STRIDE  = 4;
  localparam int W_REP     = 5;
  localparam int W_CMD     = 6;
  localparam int W_STAT    = 7;
  localparam int W_LINK_HI = 8;
  localparam int W_SRC_HI  = 9;

  localparam int CMD_IRQ  = 0;
  localparam int CMD_PLAY = 12;

  localparam logic [REG_SEL_W-1:0] RSEL_ORD_LO = 2'd0;
  localparam logic [REG_SEL_W-1:0] RSEL_ORD_HI = 2'd1;
  localparam logic [REG_SEL_W-1:0] RSEL_STAT   = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_FETCH_W, S_WORD, S_MRD, S_MRD_W,
    S_DEV_TX, S_DEV_RX, S_MWR, S_WB
  } eng_state_t;
endpackage

// File: rtl/chain_dma_order_reg.sv
module chain_dma_order_reg
  import chain_dma_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_SEL_W-1:0] wsel,
  input  logic [WORD_W-1:0]    wdata,
  input  logic                 ack_go,
  input  logic                 ack_halt,
  input  logic                 ack_wb,
  output logic [WORD_W-1:0]    ord_lo,
  output logic [WORD_W-1:0]    ord_hi
);
  logic [WORD_W-1:0] lo_nxt;

  always_comb begin
    lo_nxt = ord_lo;
    if (ack_go)   lo_nxt[ORD_GO]   = 1'b0;
    if (ack_halt) lo_nxt[ORD_HALT] = 1'b0;
    if (ack_wb)   lo_nxt[ORD_WB]   = 1'b0;
    if (wr_en && wsel == RSEL_ORD_LO) lo_nxt = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ord_lo <= '0;
      ord_hi <= '0;
    end else begin
      ord_lo <= lo_nxt;
      if (wr_en && wsel == RSEL_ORD_HI) ord_hi <= wdata;
    end
  end
endmodule

// File: rtl/chain_dma_irq.sv
module chain_dma_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   irq <= 1'b0;
    else if (set) irq <= 1'b1;
    else if (clr) irq <= 1'b0;
  end
endmodule

// File: rtl/chain_dma_engine.sv
module chain_dma_engine
  import chain_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_req,
  input  logic              halt_req,
  input  logic              wb_req,
  input  logic              addr64,
  input  logic [ADDR_W-1:0] ord_addr,
  output logic              ack_go,
  output logic              ack_halt,
  output logic              ack_wb,
  output logic              desc_irq,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [WORD_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              dev_tx_valid,
  input  logic              dev_tx_ready,
  output logic [WORD_W-1:0] dev_tx_data,
  input  logic              dev_rx_valid,
  output logic              dev_rx_ready,
  input  logic [WORD_W-1:0] dev_rx_data
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DESC_WORDS - 1);

  eng_state_t        state;
  logic [WORD_W-1:0] desc [DESC_WORDS];
  logic [IDX_W-1:0]  widx;
  logic [ADDR_W-1:0] desc_ptr, wb_base, raw_addr;
  logic              wb_ret_idle;
  logic [WORD_W-1:0] cnt, rep_left, xbuf;

  logic [ADDR_W-1:0] src_full, link_addr, word_off;
  logic              blk_end, desc_end;

  assign src_full  = {desc[W_SRC_HI], desc[W_SRC_LO]};
  assign link_addr = {desc[W_LINK_HI], desc[W_LINK_LO][WORD_W-1:ALIGN_LSB], {ALIGN_LSB{1'b0}}};
  assign word_off  = ADDR_W'({widx, 2'b00});
  assign blk_end   = (cnt == '0);
  assign desc_end  = blk_end && (rep_left <= 1);

  assign ack_go   = (state == S_IDLE) && !halt_req && !wb_req && go_req;
  assign ack_halt = (state == S_IDLE) && halt_req;
  assign ack_wb   = (state == S_WB) && mem_req_ready && (widx == LAST);
  assign desc_irq = (state == S_WORD) && !halt_req && !wb_req && desc_end
                    && desc[W_CMD][CMD_IRQ];

  assign mem_req_valid = (state == S_FETCH) || (state == S_MRD) ||
                         (state == S_WB)    || (state == S_MWR);
  assign mem_req_we    = (state == S_WB) || (state == S_MWR);
  assign mem_req_wdata = (state == S_WB) ? desc[widx] : xbuf;
  assign dev_tx_valid  = (state == S_DEV_TX);
  assign dev_tx_data   = xbuf;
  assign dev_rx_ready  = (state == S_DEV_RX);

  always_comb begin
    unique case (state)
      S_FETCH: raw_addr = desc_ptr + word_off;
      S_WB:    raw_addr = wb_base + word_off;
      default: raw_addr = src_full;
    endcase
  end
  assign mem_req_addr = addr64 ? raw_addr
                               : {{(ADDR_W-WORD_W){1'b0}}, raw_addr[WORD_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      widx        <= '0;
      desc_ptr    <= '0;
      wb_base     <= '0;
      wb_ret_idle <= 1'b0;
      cnt         <= '0;
      rep_left    <= '0;
      xbuf        <= '0;
      for (int i = 0; i < DESC_WORDS; i++) desc[i] <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (!halt_req) begin
          if (wb_req) begin
            wb_base <= ord_addr; widx <= '0; wb_ret_idle <= 1'b1; state <= S_WB;
          end else if (go_req) begin
            desc_ptr <= ord_addr; widx <= '0; state <= S_FETCH;
          end
        end
        S_FETCH: if (mem_req_ready) state <= S_FETCH_W;
        S_FETCH_W: if (mem_rsp_valid) begin
          desc[widx] <= mem_rsp_data;
          if (halt_req) state <= S_IDLE;
          else if (widx == LAST) begin
            cnt      <= desc[W_LEN];
            rep_left <= (desc[W_REP] == '0) ? WORD_W'(1) : desc[W_REP];
            state    <= S_WORD;
          end else begin
            widx  <= widx + 1'b1;
            state <= S_FETCH;
          end
        end
        S_WORD: begin
          if (halt_req) state <= S_IDLE;
          else if (wb_req) begin
            wb_base <= ord_addr; widx <= '0; wb_ret_idle <= 1'b0; state <= S_WB;
          end else if (!blk_end) begin
            state <= desc[W_CMD][CMD_PLAY] ? S_MRD : S_DEV_RX;
          end else if (!desc_end) begin
            rep_left <= rep_left - 1'b1;
            cnt      <= desc[W_LEN];
            {desc[W_SRC_HI], desc[W_SRC_LO]} <= src_full + {{(ADDR_W-WORD_W){1'b0}}, desc[W_STRIDE]};
          end else if (desc[W_LINK_LO][0]) begin
            desc_ptr <= link_addr; widx <= '0; state <= S_FETCH;
          end else state <= S_IDLE;
        end
        S_MRD: if (mem_req_ready) state <= S_MRD_W;
        S_MRD_W: if (mem_rsp_valid) begin
          xbuf  <= mem_rsp_data;
          state <= S_DEV_TX;
        end
        S_DEV_TX: if (dev_tx_ready) begin
          {desc[W_SRC_HI], desc[W_SRC_LO]} <= src_full + ADDR_W'(4);
          cnt   <= cnt - 1'b1;
          state <= S_WORD;
        end
        S_DEV_RX: if (dev_rx_valid) begin
          xbuf  <= dev_rx_data;
          state <= S_MWR;
        end
        S_MWR: if (mem_req_ready) begin
          {desc[W_SRC_HI], desc[W_SRC_LO]} <= src_full + ADDR_W'(4);
          cnt   <= cnt - 1'b1;
          state <= S_WORD;
        end
        S_WB: if (mem_req_ready) begin
          if (widx == LAST) state <= wb_ret_idle ? S_IDLE : S_WORD;
          else widx <= widx + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chain_dma.sv
module chain_dma
  import chain_dma_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_en,
  input  logic [REG_SEL_W-1:0] reg_sel,
  input  logic [WORD_W-1:0]    reg_wdata,
  output logic [WORD_W-1:0]    reg_rdata,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic                 mem_req_we,
  output logic [ADDR_W-1:0]    mem_req_addr,
  output logic [WORD_W-1:0]    mem_req_wdata,
  input  logic                 mem_rsp_valid,
  input  logic [WORD_W-1:0]    mem_rsp_data,
  output logic                 dev_tx_valid,
  input  logic                 dev_tx_ready,
  output logic [WORD_W-1:0]    dev_tx_data,
  input  logic                 dev_rx_valid,
  output logic                 dev_rx_ready,
  input  logic [WORD_W-1:0]    dev_rx_data,
  output logic                 irq
);
  logic [WORD_W-1:0] ord_lo, ord_hi;
  logic [ADDR_W-1:0] ord_addr;
  logic              ack_go, ack_halt, ack_wb, desc_irq, irq_clr;
  logic              addr64;

  assign ord_addr = {ord_hi, ord_lo[WORD_W-1:ALIGN_LSB], {ALIGN_LSB{1'b0}}};
  assign addr64   = ord_lo[ORD_A64];
  assign irq_clr  = reg_wr_en && (reg_sel == RSEL_STAT) && reg_wdata[0];

  chain_dma_order_reg u_order (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wsel(reg_sel), .wdata(reg_wdata),
    .ack_go(ack_go), .ack_halt(ack_halt), .ack_wb(ack_wb),
    .ord_lo(ord_lo), .ord_hi(ord_hi)
  );

  chain_dma_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set(desc_irq), .clr(irq_clr), .irq(irq)
  );

  chain_dma_engine u_eng (
    .clk(clk), .rst_n(rst_n),
    .go_req(ord_lo[ORD_GO]), .halt_req(ord_lo[ORD_HALT]), .wb_req(ord_lo[ORD_WB]),
    .addr64(addr64), .ord_addr(ord_addr),
    .ack_go(ack_go), .ack_halt(ack_halt), .ack_wb(ack_wb), .desc_irq(desc_irq),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .dev_tx_valid(dev_tx_valid), .dev_tx_ready(dev_tx_ready), .dev_tx_data(dev_tx_data),
    .dev_rx_valid(dev_rx_valid), .dev_rx_ready(dev_rx_ready), .dev_rx_data(dev_rx_data)
  );

  always_comb begin
    unique case (reg_sel)
      RSEL_ORD_LO: reg_rdata = ord_lo;
      RSEL_ORD_HI: reg_rdata = ord_hi;
      RSEL_STAT:   reg_rdata = {{(WORD_W-1){1'b0}}, irq};
      default:     reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/chain_dma_checker.sv
module chain_dma_checker
  import chain_dma_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr_en,
  input logic [REG_SEL_W-1:0] reg_sel,
  input logic [WORD_W-1:0]    reg_wdata,
  input logic                 mem_req_valid,
  input logic                 mem_req_ready,
  input logic                 mem_req_we,
  input logic [ADDR_W-1:0]    mem_req_addr,
  input logic [WORD_W-1:0]    mem_req_wdata,
  input logic                 dev_tx_valid,
  input logic                 dev_tx_ready,
  input logic [WORD_W-1:0]    dev_tx_data,
  input logic                 dev_rx_ready,
  input logic                 irq,
  input logic                 addr64
);
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata));

  p_tx_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dev_tx_valid && !dev_tx_ready |=> dev_tx_valid && $stable(dev_tx_data));

  p_irq_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !(reg_wr_en && reg_sel == RSEL_STAT && reg_wdata[0]) |=> irq);

  p_word_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[1:0] == 2'b00);

  p_addr32_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !addr64 |-> mem_req_addr[ADDR_W-1:WORD_W] == '0);

  p_dir_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_tx_valid && dev_rx_ready));
endmodule

bind chain_dma chain_dma_checker i_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
  .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
  .dev_tx_valid(dev_tx_valid), .dev_tx_ready(dev_tx_ready), .dev_tx_data(dev_tx_data),
  .dev_rx_ready(dev_rx_ready), .irq(irq), .addr64(addr64)
);

// File: tb/test_chain_dma.sv
module test_chain_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mem_req_valid, mem_req_ready, mem_req_we;
  logic [63:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = 32'd0;
  logic        dev_tx_valid, dev_tx_ready, dev_rx_valid, dev_rx_ready;
  logic [31:0] dev_tx_data, dev_rx_data;
  logic        irq;

  logic [31:0] cyc = 32'd0;
  logic        bp_on = 1'b0, tx_slow = 1'b0, rx_on = 1'b0;
  logic [31:0] mem [0:4095];
  logic [31:0] tx_log [0:255];
  logic [63:0] req_log [0:255];
  int          tx_count = 0, rx_count = 0, req_count = 0, snap = 0;
  logic [63:0] wb_watch = 64'h404;
  int          tests = 0, fails = 0;

  always #5 clk = ~clk;

  assign mem_req_ready = bp_on ? cyc[1] : 1'b1;
  assign dev_tx_ready  = tx_slow ? (cyc[1:0] == 2'b11) : 1'b1;
  assign dev_rx_valid  = rx_on;
  assign dev_rx_data   = 32'hC0DE_0000 + rx_count;

  chain_dma i_chain_dma (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .dev_tx_valid(dev_tx_valid), .dev_tx_ready(dev_tx_ready), .dev_tx_data(dev_tx_data),
    .dev_rx_valid(dev_rx_valid), .dev_rx_ready(dev_rx_ready), .dev_rx_data(dev_rx_data),
    .irq(irq)
  );

  // memory and device models
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      req_log[req_count[7:0]] <= mem_req_addr;
      req_count <= req_count + 1;
      if (mem_req_we) begin
        mem[mem_req_addr[13:2]] <= mem_req_wdata;
        if (mem_req_addr == wb_watch) snap <= tx_count;
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[mem_req_addr[13:2]];
      end
    end
    if (dev_tx_valid && dev_tx_ready) begin
      tx_log[tx_count[7:0]] <= dev_tx_data;
      tx_count <= tx_count + 1;
    end
    if (dev_rx_valid && dev_rx_ready) rx_count <= rx_count + 1;
  end

  function automatic logic [31:0] pat(input logic [31:0] a);
    return 32'hD000_0000 | a;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    @(negedge clk);
    reg_sel = sel;
    #1 v = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_tx(input int n);
    for (int g = 0; g < 20000 && tx_count < n; g++) @(negedge clk);
  endtask

  task automatic wait_bit_clear(input int b);
    logic [31:0] v;
    v = 32'hFFFF_FFFF;
    for (int g = 0; g < 5000 && v[b]; g++) rd(2'd0, v);
  endtask

  // descriptor: link_lo, src_lo, len, stride, rep, cmd (16 words, rest zero)
  task automatic put_desc(input int base, input logic [31:0] link, input logic [31:0] src,
                          input logic [31:0] len, input logic [31:0] stride,
                          input logic [31:0] rep, input logic [31:0] cmd);
    for (int k = 0; k < 16; k++) mem[base/4 + k] = 32'd0;
    mem[base/4 + 0] = link;
    mem[base/4 + 1] = src;
    mem[base/4 + 2] = 32'hF00;
    mem[base/4 + 3] = len;
    mem[base/4 + 4] = stride;
    mem[base/4 + 5] = rep;
    mem[base/4 + 6] = cmd;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 irq", {63'd0, irq}, 64'd0);
    chk("R1 req", {63'd0, mem_req_valid}, 64'd0);
    chk("R1 dev", {62'd0, dev_tx_valid, dev_rx_ready}, 64'd0);
    rd(2'd0, v); chk("R1 order", {32'd0, v}, 64'd0);
    rd(2'd2, v); chk("R1 status", {32'd0, v}, 64'd0);
  endtask

  task automatic t_playback;
    logic [31:0] v;
    int tb0, rb0;
    tb0 = tx_count; rb0 = req_count;
    bp_on = 1'b1; tx_slow = 1'b1;
    put_desc(32'h100, 32'h0, 32'h1000, 32'd4, 32'd0, 32'd1, 32'h1001);
    wr(2'd0, 32'h108);
    wait_tx(tb0 + 4);
    idle(20);
    chk("R2 fetch addr", req_log[rb0[7:0]], 64'h100);
    for (int k = 0; k < 4; k++)
      chk("R4 R12 playback word", {32'd0, tx_log[(tb0 + k) % 256]}, {32'd0, pat(32'h1000 + 4*k)});
    chk("R4 word count", 64'(tx_count - tb0), 64'd4);
    rd(2'd0, v); chk("R2 go bit cleared", {32'd0, v}, 64'h100);
    chk("R7 irq raised", {63'd0, irq}, 64'd1);
    idle(10);
    rd(2'd2, v); chk("R7 irq held", {32'd0, v}, 64'd1);
    wr(2'd2, 32'd1);
    chk("R7 irq cleared", {63'd0, irq}, 64'd0);
    bp_on = 1'b0; tx_slow = 1'b0;
  endtask

  task automatic t_capture_chain;
    int xb0, rq;
    xb0 = rx_count;
    put_desc(32'h200, 32'h241, 32'h2000, 32'd3, 32'd0, 32'd1, 32'h1);
    put_desc(32'h240, 32'h0,   32'h2100, 32'd3, 32'd0, 32'd1, 32'h0);
    rx_on = 1'b1;
    wr(2'd0, 32'h208);
    for (int g = 0; g < 5000 && rx_count < xb0 + 6; g++) @(negedge clk);
    idle(30);
    rx_on = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R5 capture A", {32'd0, mem[32'h2000/4 + k]}, {32'd0, 32'hC0DE_0000 + xb0 + k});
      chk("R6 capture B", {32'd0, mem[32'h2100/4 + k]}, {32'd0, 32'hC0DE_0000 + xb0 + 3 + k});
    end
    chk("R6 stopped after chain", 64'(rx_count - xb0), 64'd6);
    rq = req_count;
    idle(30);
    chk("R6 no requests at end", 64'(req_count), 64'(rq));
    wr(2'd2, 32'd1);
  endtask

  task automatic t_ring_halt;
    int tb0, rq, tq;
    logic [31:0] v;
    tb0 = tx_count;
    put_desc(32'h280, 32'h2C1, 32'h1000, 32'd4, 32'd0, 32'd1, 32'h1000);
    put_desc(32'h2C0, 32'h281, 32'h1100, 32'd4, 32'd0, 32'd1, 32'h1000);
    wr(2'd0, 32'h288);
    wait_tx(tb0 + 12);
    for (int k = 0; k < 4; k++) begin
      chk("R6 ring B", {32'd0, tx_log[(tb0 + 4 + k) % 256]}, {32'd0, pat(32'h1100 + 4*k)});
      chk("R6 ring wraps to A", {32'd0, tx_log[(tb0 + 8 + k) % 256]}, {32'd0, pat(32'h1000 + 4*k)});
    end
    wr(2'd0, 32'h10);
    wait_bit_clear(4);
    rd(2'd0, v); chk("R9 halt bit cleared", {63'd0, v[4]}, 64'd0);
    idle(2);
    rq = req_count; tq = tx_count;
    idle(40);
    chk("R9 no requests after halt", 64'(req_count), 64'(rq));
    chk("R9 no device words after halt", 64'(tx_count), 64'(tq));
  endtask

  task automatic t_writeback;
    int tb0;
    logic [31:0] v;
    tb0 = tx_count;
    tx_slow = 1'b1;
    put_desc(32'h300, 32'h0, 32'h1200, 32'd40, 32'd0, 32'd1, 32'h1000);
    wr(2'd0, 32'h308);
    wait_tx(tb0 + 5);
    wr(2'd0, 32'h404);
    wait_bit_clear(2);
    rd(2'd0, v); chk("R8 wb bit cleared", {63'd0, v[2]}, 64'd0);
    chk("R8 stored position", {32'd0, mem[32'h404/4]}, {32'd0, 32'h1200 + 4*(snap - tb0)});
    chk("R8 stored length", {32'd0, mem[32'h40C/4]}, 64'd40);
    chk("R8 stored command", {32'd0, mem[32'h418/4]}, 64'h1000);
    wait_tx(tb0 + 40);
    idle(20);
    chk("R8 transfer continues", 64'(tx_count - tb0), 64'd40);
    chk("R8 last word", {32'd0, tx_log[(tb0 + 39) % 256]}, {32'd0, pat(32'h1200 + 4*39)});
    tx_slow = 1'b0;
  endtask

  task automatic t_stride;
    int tb0;
    logic [31:0] exp_a [0:7];
    tb0 = tx_count;
    exp_a[0] = 32'h1000; exp_a[1] = 32'h1004; exp_a[2] = 32'h1018; exp_a[3] = 32'h101C;
    exp_a[4] = 32'h1030; exp_a[5] = 32'h1034; exp_a[6] = 32'h1300; exp_a[7] = 32'h1304;
    put_desc(32'h340, 32'h381, 32'h1000, 32'd2, 32'h10, 32'd3, 32'h1000);
    put_desc(32'h380, 32'h0,   32'h1300, 32'd2, 32'h40, 32'd0, 32'h1000);
    wr(2'd0, 32'h348);
    wait_tx(tb0 + 8);
    idle(40);
    for (int k = 0; k < 8; k++)
      chk("R11 stride sequence", {32'd0, tx_log[(tb0 + k) % 256]}, {32'd0, pat(exp_a[k])});
    chk("R11 repeat zero is one", 64'(tx_count - tb0), 64'd8);
  endtask

  task automatic t_addr64;
    int rb0;
    put_desc(32'h3C0, 32'h0, 32'h1000, 32'd0, 32'd0, 32'd1, 32'h0);
    wr(2'd1, 32'h1);
    rb0 = req_count;
    wr(2'd0, 32'h3C8);
    idle(40);
    chk("R10 upper zero in 32-bit mode", req_log[rb0[7:0]], 64'h3C0);
    chk("R3 ten word fetch", 64'(req_count - rb0), 64'd10);
    chk("R3 last fetch offset", req_log[(rb0 + 9) % 256], 64'h3E4);
    rb0 = req_count;
    wr(2'd0, 32'h3C9);
    idle(40);
    chk("R10 full address in 64-bit mode", req_log[rb0[7:0]], 64'h1_0000_03C0);
    wr(2'd1, 32'h0);
    wr(2'd0, 32'h0);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = pat(32'(i) << 2);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    t_reset;
    t_playback;
    t_capture_chain;
    t_ring_halt;
    t_writeback;
    t_stride;
    t_addr64;
    summary;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary;
  end
endmodule